// File: doc/BRIEF.md
# Random Byte Source Register Block

This block is a small memory-mapped peripheral that hands random bytes to a host processor. It has three byte-wide registers on a simple strobe-qualified bus: a control word (run bit, data-ready flag, a stored 4-bit prescaler and two spare bits), a read-only byte register and a mode byte. A byte from an entropy source is captured only when the host polls the control word while the generator is running and no byte is waiting. The host then collects that byte with a read of the byte register, and the read consumes it.

The entropy input is a valid/data pair with an acknowledge pulse back to the source. A parameter selects instead an internal 8-bit maximal-length shift register that is always ready. This lets the block stand alone in a bench or in a bring-up build. Register updates land on the clock edge that ends the access. Read data is combinational during the strobe cycle, and it shows the state that the access itself produces.

Top module: `rng_regblock`

## Requirements
- R1: After reset the control word, the byte register and the mode byte are all zero.
- R2: A register is selected only when the strobe is high, the address is exactly 0x000 (control), 0x004 (byte) or 0x008 (mode), and byte lane 0 is enabled (bus_be[0]=1). The register occupies read data bits 7:0, and read data bits 31:8 are always 0.
- R3: The generator is running only when control bit 0 is 1 and the mode byte equals 0x02 exactly. Any other mode value blocks capture and delivery.
- R4: A control-word read while the generator is not running clears the ready flag (control bit 1). The returned value already shows the cleared flag.
- R5: A control-word read while running, with the ready flag clear and ent_valid high, loads ent_data into the byte register and sets the ready flag. ent_ack pulses in that same cycle, and the returned value shows the ready flag set.
- R6: A control-word read while running, with the ready flag clear and ent_valid low, changes nothing, keeps ent_ack low and returns the control word unchanged.
- R7: A byte-register read while running with the ready flag set returns the byte, clears the flag and zeroes the stored byte. Any other byte-register read returns 0 and changes nothing.
- R8: A control-word write stores bits 7:2 and bit 0 from write data. The ready flag keeps its previous value whatever is written to bit 1.
- R9: Writes to the byte register are ignored. A mode write stores all 8 written bits, and they read back unchanged.
- R10: Accesses to any other address, to a misaligned address (bits 1:0 non-zero), or with bus_be[0]=0 read 0 and modify no register.
- R11: With the internal source selected, every capturing poll loads the current shift-register state. That state is never zero, and successive captured bytes differ.
- R12: A control-word read while the ready flag is already set captures nothing, leaves the stored byte intact and keeps ent_ack low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_be | input | 4 | Byte-lane enables, little-endian |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the strobe cycle |
| ent_valid | input | 1 | Entropy byte available |
| ent_data | input | 8 | Entropy byte |
| ent_ack | output | 1 | Entropy byte taken this cycle |

## Verification
Two things can meet in one cycle: a control-word poll and the arrival (or absence) of an entropy byte. The poll can also find a byte already waiting. The bench holds ent_valid high or low during polls in each of the running, stopped and already-ready states. It judges each poll by the returned control word and by ent_ack in that same cycle. A later byte-register read then shows whether the byte that was kept was the first one offered and not a newer one.

// File: rtl/rng_regblock.sv
module rng_regblock #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W = 8,
  parameter bit INTERNAL_SRC = 1'b0,
  parameter logic [7:0] LFSR_SEED = 8'h5A,
  parameter logic [7:0] LFSR_TAPS = 8'hB8,
  parameter logic [7:0] MODE_RUN = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic [REG_W-1:0]  ent_data,
  output logic              ent_ack
);

  localparam logic [ADDR_W-1:0] OFF_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_BYTE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(8);
  localparam int RUN_BIT = 0;
  localparam int RDY_BIT = 1;

  logic [REG_W-1:0] ctl_q, byte_q, mode_q;
  logic [REG_W-1:0] ctl_d, byte_d, mode_d;
  logic [REG_W-1:0] src_byte;
  logic             src_valid;

  wire access_ok = bus_sel && (bus_addr[1:0] == 2'b00) && bus_be[0];
  wire hit_ctl   = access_ok && (bus_addr == OFF_CTL);
  wire hit_byte  = access_ok && (bus_addr == OFF_BYTE);
  wire hit_mode  = access_ok && (bus_addr == OFF_MODE);

  wire rd_ctl  = hit_ctl  && !bus_we;
  wire wr_ctl  = hit_ctl  &&  bus_we;
  wire rd_byte = hit_byte && !bus_we;
  wire rd_mode = hit_mode && !bus_we;
  wire wr_mode = hit_mode &&  bus_we;

  wire running = ctl_q[RUN_BIT] && (mode_q == MODE_RUN);
  wire ready   = ctl_q[RDY_BIT];
  wire capture = rd_ctl && running && !ready && src_valid;
  wire consume = rd_byte && running && ready;

  wire unused_inputs = &{1'b0, bus_wdata[DATA_W-1:REG_W], bus_be[DATA_W/8-1:1],
                         ent_valid, ent_data};

  generate
    if (INTERNAL_SRC) begin : g_lfsr
      logic [REG_W-1:0] lfsr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= REG_W'(LFSR_SEED);
        else        lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ REG_W'(LFSR_TAPS)) : (lfsr_q >> 1);
      end
      assign src_byte  = lfsr_q;
      assign src_valid = 1'b1;
      assign ent_ack   = 1'b0;
    end else begin : g_port
      assign src_byte  = ent_data;
      assign src_valid = ent_valid;
      assign ent_ack   = capture;
      a_r5_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl && running && !ready && ent_valid) |=> (ctl_q[RDY_BIT] && byte_q == $past(ent_data)));
      a_r12_no_ack_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !ent_ack);
    end
  endgenerate

  always_comb begin
    logic rdy_d;
    rdy_d = ready;
    if (rd_ctl)       rdy_d = running ? (ready | capture) : 1'b0;
    else if (consume) rdy_d = 1'b0;
    ctl_d = ctl_q;
    ctl_d[RDY_BIT] = rdy_d;
    if (wr_ctl) begin
      ctl_d = bus_wdata[REG_W-1:0];
      ctl_d[RDY_BIT] = ready;
    end
  end

  assign byte_d = capture ? src_byte : (consume ? '0 : byte_q);
  assign mode_d = wr_mode ? bus_wdata[REG_W-1:0] : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      byte_q <= '0;
      mode_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      byte_q <= byte_d;
      mode_q <= mode_d;
    end
  end

  assign bus_rdata = DATA_W'(rd_ctl  ? ctl_d  :
                             consume ? byte_q :
                             rd_mode ? mode_q : '0);

  a_r4_stopped_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && !running) |=> !ctl_q[RDY_BIT]);
  a_r7_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_byte && running && ready) |=> (!ctl_q[RDY_BIT] && byte_q == '0));
  a_r8_write_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_q[RDY_BIT] == $past(ctl_q[RDY_BIT])));
  a_r9_byte_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_byte && bus_we) |=> ($stable(byte_q) && $stable(ctl_q)));
  a_r10_stray_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !access_ok) |=> ($stable(ctl_q) && $stable(byte_q) && $stable(mode_q)));
  a_r10_stray_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !access_ok) |-> (bus_rdata == '0));
  a_r2_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:REG_W] == '0);
  a_r12_ready_poll_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && running && ready) |=> ($stable(byte_q) && ctl_q[RDY_BIT]));

endmodule

// File: tb/sim_rng_regblock.sv
`timescale 1ns/1ps
module sim_rng_regblock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel0 = 1'b0, sel1 = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0] be = 4'h1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic ent_valid = 1'b0;
  logic [7:0] ent_data = '0;
  logic ack0, ack1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rng_regblock u0 (.clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_we(we), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata0), .ent_valid(ent_valid),
    .ent_data(ent_data), .ent_ack(ack0));
  rng_regblock #(.INTERNAL_SRC(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_we(we),
    .bus_addr(addr), .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata1), .ent_valid(ent_valid),
    .ent_data(ent_data), .ent_ack(ack1));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit which, input bit w, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] lanes, output logic [31:0] rd, output logic ak);
    @(negedge clk);
    we = w; addr = a; wdata = d; be = lanes;
    if (which) sel1 = 1'b1; else sel0 = 1'b1;
    #1;
    rd = which ? rdata1 : rdata0;
    ak = which ? ack1 : ack0;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic k;
    acc(1'b0, 1'b1, a, d, 4'h1, r, k);
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input bit exp_ack, input string tag);
    logic [31:0] r; logic k;
    acc(1'b0, 1'b0, a, 32'h0, 4'hF, r, k);
    check(r == exp, tag, r, exp);
    check(k == exp_ack, {tag, " ack"}, {31'h0, k}, {31'h0, exp_ack});
  endtask

  task automatic arm(input logic [7:0] b);
    ent_valid = 1'b1; ent_data = b;
    rd_expect(12'h000, 32'h3, 1'b1, "R5 arm poll");
    ent_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_expect(12'h000, 32'h0, 1'b0, "R1 control reset");
    rd_expect(12'h008, 32'h0, 1'b0, "R1 mode reset");
    rd_expect(12'h004, 32'h0, 1'b0, "R1 byte reset");
  endtask

  task automatic t_gate;
    wr(12'h000, 32'h1);
    wr(12'h008, 32'h3);
    ent_valid = 1'b1; ent_data = 8'hA5;
    rd_expect(12'h000, 32'h1, 1'b0, "R3 wrong mode blocks capture");
    wr(12'h008, 32'h2);
    rd_expect(12'h000, 32'h3, 1'b1, "R5 poll captures");
    ent_valid = 1'b0;
    rd_expect(12'h004, 32'hA5, 1'b0, "R7 byte read returns");
    rd_expect(12'h000, 32'h1, 1'b0, "R6 no byte offered");
    rd_expect(12'h004, 32'h0, 1'b0, "R7 empty read zero");
  endtask

  task automatic t_ready_held;
    arm(8'h3C);
    ent_valid = 1'b1; ent_data = 8'h77;
    rd_expect(12'h000, 32'h3, 1'b0, "R12 ready poll no capture");
    ent_valid = 1'b0;
    rd_expect(12'h004, 32'h3C, 1'b0, "R12 first byte kept");
  endtask

  task automatic t_ctl_write;
    arm(8'h11);
    wr(12'h000, 32'h3D);
    rd_expect(12'h000, 32'h3F, 1'b0, "R8 ready kept through write");
    rd_expect(12'h004, 32'h11, 1'b0, "R8 byte intact");
    wr(12'h000, 32'h03);
    rd_expect(12'h000, 32'h01, 1'b0, "R8 ready not writable");
  endtask

  task automatic t_stop;
    arm(8'h22);
    wr(12'h008, 32'h0);
    rd_expect(12'h004, 32'h0, 1'b0, "R7 stopped read zero");
    wr(12'h008, 32'h2);
    rd_expect(12'h004, 32'h22, 1'b0, "R7 stopped read had no effect");
    arm(8'h44);
    wr(12'h008, 32'h0);
    rd_expect(12'h000, 32'h1, 1'b0, "R4 stopped poll clears ready");
    wr(12'h008, 32'h2);
    rd_expect(12'h004, 32'h0, 1'b0, "R4 byte gone after clear");
  endtask

  task automatic t_writes;
    wr(12'h008, 32'hFF);
    rd_expect(12'h008, 32'hFF, 1'b0, "R9 mode full byte");
    wr(12'h008, 32'h02);
    arm(8'h5E);
    wr(12'h004, 32'h00);
    rd_expect(12'h004, 32'h5E, 1'b0, "R9 byte write ignored");
  endtask

  task automatic t_stray;
    logic [31:0] r; logic k;
    wr(12'h00C, 32'hC3);
    wr(12'h009, 32'hC3);
    wr(12'h800, 32'hC3);
    rd_expect(12'h008, 32'h02, 1'b0, "R10 stray writes no effect");
    rd_expect(12'h00C, 32'h0, 1'b0, "R10 unmapped read zero");
    ent_valid = 1'b1; ent_data = 8'h99;
    rd_expect(12'h002, 32'h0, 1'b0, "R10 misaligned poll inert");
    acc(1'b0, 1'b0, 12'h000, 32'h0, 4'h2, r, k);
    check(r == 32'h0 && !k, "R2 lane0 off read inert", r, 32'h0);
    acc(1'b0, 1'b1, 12'h008, 32'h07, 4'hE, r, k);
    rd_expect(12'h008, 32'h02, 1'b0, "R2 lane0 off write ignored");
    rd_expect(12'h000, 32'h3, 1'b1, "R2 upper lanes zero");
    ent_valid = 1'b0;
    rd_expect(12'h004, 32'h99, 1'b0, "R10 first real poll took byte");
  endtask

  task automatic t_internal;
    logic [31:0] r, v1, v2; logic k;
    acc(1'b1, 1'b1, 12'h000, 32'h1, 4'h1, r, k);
    acc(1'b1, 1'b1, 12'h008, 32'h2, 4'h1, r, k);
    acc(1'b1, 1'b0, 12'h000, 32'h0, 4'h1, r, k);
    check(r == 32'h3, "R11 internal poll captures", r, 32'h3);
    acc(1'b1, 1'b0, 12'h004, 32'h0, 4'h1, v1, k);
    check(v1 != 0, "R11 byte nonzero", v1, 32'h1);
    acc(1'b1, 1'b0, 12'h000, 32'h0, 4'h1, r, k);
    acc(1'b1, 1'b0, 12'h004, 32'h0, 4'h1, v2, k);
    check(v2 != 0 && v2 != v1, "R11 successive bytes differ", v2, v1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_ready_held();
    t_ctl_write();
    t_stop();
    t_writes();
    t_stray();
    t_internal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule